// File: doc/BRIEF.md
# External memory bus cycle sequencer

The sequencer is a bus master for a parallel external memory bus. It accepts one internal request at a time and turns it into a bus cycle. A request carries an address, a bank number, a direction, a burst flag and a calibration flag. For each cycle the sequencer drives a one-clock start strobe, one of four bank selects, an output-enable strobe, a direction line and a burst-in-progress line. It samples the slave's acknowledge to step through the data beats and to end the cycle. Every strobe is active low.

A single transfer ends on the first acknowledge. A read burst has four beats and ends on the fourth acknowledge. A write ends on its first acknowledge even when it is a burst, because the slave acknowledges a write only once. A calibration access uses the same timing, but it keeps the bank selects and output enable idle, and it drives the direction line from a separate calibration direction input. For each acknowledged beat, the internal side gets a one-clock done pulse. For reads it also gets the data that was on the bus when the acknowledge was sampled.

The controller has three states. In IDLE, `req_ready` is high. A valid request moves it to START, which is the single clock with the start strobe low. START always moves on to DATA. DATA stays in DATA while no acknowledge arrives, or while a read burst still has beats left (the beat count goes up by one on each acknowledge). DATA moves back to IDLE on the acknowledge that ends the cycle.

Top module: `ext_bus_seq`

## Requirements
- R1: A request is accepted only on a clock where `req_ready` (IDLE) is high. `bus_ts_n` goes low for exactly the one clock that follows acceptance, and only then.
- R2: On a non-calibration cycle, `bus_cs_n[bank]` is low from the start-strobe clock through the clock in which the ending acknowledge is sampled. All other selects stay high. All selects are high in IDLE.
- R3: `bus_rd_wr` is 1 for a read and 0 for a write. It is valid from the start-strobe clock until the cycle ends, and it is 1 in IDLE.
- R4: On a non-calibration read, `bus_oe_n` goes low in the clock after the start strobe and stays low through the ending acknowledge. On a write it stays high for the whole cycle.
- R5: A read with the burst flag set takes four beats: one acknowledge per beat, and the cycle ends on the fourth. A read without the flag ends on its first acknowledge.
- R6: A write ends on its first acknowledge, whether or not the burst flag is set.
- R7: On a burst cycle, `bus_burst_n` is low from the start-strobe clock. For reads it goes high during the fourth beat. For writes it stays low until the cycle ends. It is high on single cycles and in IDLE.
- R8: On a calibration access, every `bus_cs_n` bit and `bus_oe_n` stay high, and `bus_rd_wr` equals the present value of `cal_rd_wr`.
- R9: `rsp_done` is high for one clock, in the clock after each acknowledge is sampled in DATA. After a read beat, `rsp_rdata` holds the `bus_din` value sampled with that acknowledge.
- R10: An acknowledge in IDLE or in the start-strobe clock is ignored.
- R11: `bus_addr` holds the accepted request address from the start-strobe clock until the cycle ends.
- R12: While reset is held and right after it, the block is in IDLE: `req_ready` is 1, all strobes are high, and `rsp_done` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle, request taken this clock |
| req_addr | input | ADDR_W | Request address |
| req_bank | input | BANK_W | Bank select number (0..NUM_CS-1) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_burst | input | 1 | Four-beat burst |
| req_cal | input | 1 | Calibration-bus access |
| cal_rd_wr | input | 1 | Direction driven during calibration accesses |
| bus_addr | output | ADDR_W | Bus address |
| bus_ts_n | output | 1 | Transfer start, active low |
| bus_cs_n | output | NUM_CS | Bank selects, active low |
| bus_oe_n | output | 1 | Output enable, active low |
| bus_rd_wr | output | 1 | Direction, 1 = read |
| bus_burst_n | output | 1 | Burst in progress, active low |
| bus_ta_n | input | 1 | Transfer acknowledge, active low |
| bus_din | input | DATA_W | Read data from the bus |
| rsp_done | output | 1 | Beat completed pulse |
| rsp_rdata | output | DATA_W | Captured read data |

## Verification
The bench drives the acknowledge at random, and this includes acknowledges in IDLE and in the start clock. A design that counted those acknowledges would end cycles early and put the done pulses out of line. Write bursts are mixed in with read bursts. A design that counted write beats would hang in DATA until three more acknowledges arrived. Calibration accesses run while `cal_rd_wr` toggles. A latched or ignored calibration direction, or a select that leaks onto the bus, shows up as a mismatch on the same clock. New requests are held valid while the sequencer is busy, so a sequencer that accepts early would start a second cycle before the first one ends.

// File: rtl/ebs_pkg.sv
package ebs_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_START = 2'd1,
        ST_DATA  = 2'd2
    } seq_state_t;
endpackage

// File: rtl/ebs_fsm.sv
module ebs_fsm
    import ebs_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int BANK_W    = 2,
    parameter int BURST_LEN = 4,
    parameter int BEAT_W    = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [BANK_W-1:0] req_bank,
    input  logic              req_write,
    input  logic              req_burst,
    input  logic              req_cal,
    input  logic              bus_ta_n,
    output seq_state_t        state,
    output logic [BEAT_W-1:0] beat,
    output logic [ADDR_W-1:0] lat_addr,
    output logic [BANK_W-1:0] lat_bank,
    output logic              lat_write,
    output logic              lat_burst,
    output logic              lat_cal,
    output logic              beat_ack
);
    localparam logic [BEAT_W-1:0] LAST_BEAT = BEAT_W'(BURST_LEN - 1);

    seq_state_t        state_nx;
    logic [BEAT_W-1:0] beat_nx;
    logic              take;
    logic              final_beat;

    assign take       = (state == ST_IDLE) && req_valid;
    assign beat_ack   = (state == ST_DATA) && !bus_ta_n;
    assign final_beat = lat_write || !lat_burst || (beat == LAST_BEAT);

    always_comb begin
        state_nx = state;
        beat_nx  = beat;
        unique case (state)
            ST_IDLE: begin
                if (take) begin
                    state_nx = ST_START;
                    beat_nx  = '0;
                end
            end
            ST_START: state_nx = ST_DATA;
            ST_DATA: begin
                if (beat_ack) begin
                    if (final_beat) state_nx = ST_IDLE;
                    else            beat_nx  = beat + 1'b1;
                end
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            beat  <= '0;
        end else begin
            state <= state_nx;
            beat  <= beat_nx;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lat_addr  <= '0;
            lat_bank  <= '0;
            lat_write <= 1'b0;
            lat_burst <= 1'b0;
            lat_cal   <= 1'b0;
        end else if (take) begin
            lat_addr  <= req_addr;
            lat_bank  <= req_bank;
            lat_write <= req_write;
            lat_burst <= req_burst;
            lat_cal   <= req_cal;
        end
    end
endmodule

// File: rtl/ebs_strobes.sv
module ebs_strobes
    import ebs_pkg::*;
#(
    parameter int NUM_CS    = 4,
    parameter int BANK_W    = 2,
    parameter int BURST_LEN = 4,
    parameter int BEAT_W    = 2
) (
    input  seq_state_t        state,
    input  logic [BEAT_W-1:0] beat,
    input  logic [BANK_W-1:0] lat_bank,
    input  logic              lat_write,
    input  logic              lat_burst,
    input  logic              lat_cal,
    input  logic              cal_rd_wr,
    output logic              req_ready,
    output logic              bus_ts_n,
    output logic [NUM_CS-1:0] bus_cs_n,
    output logic              bus_oe_n,
    output logic              bus_rd_wr,
    output logic              bus_burst_n
);
    localparam logic [BEAT_W-1:0] LAST_BEAT = BEAT_W'(BURST_LEN - 1);

    logic busy;
    logic last_rd_beat;

    always_comb begin
        busy         = (state != ST_IDLE);
        last_rd_beat = !lat_write && (beat == LAST_BEAT);
        req_ready    = (state == ST_IDLE);
        bus_ts_n     = !(state == ST_START);
        bus_oe_n     = !((state == ST_DATA) && !lat_write && !lat_cal);
        if (!busy)        bus_rd_wr = 1'b1;
        else if (lat_cal) bus_rd_wr = cal_rd_wr;
        else              bus_rd_wr = !lat_write;
        bus_burst_n  = !(lat_burst && ((state == ST_START) ||
                         ((state == ST_DATA) && !last_rd_beat)));
    end

    for (genvar g = 0; g < NUM_CS; g++) begin : g_cs
        assign bus_cs_n[g] = !(busy && !lat_cal && (lat_bank == BANK_W'(g)));
    end
endmodule

// File: rtl/ebs_capture.sv
module ebs_capture #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              beat_ack,
    input  logic              lat_write,
    input  logic [DATA_W-1:0] bus_din,
    output logic              rsp_done,
    output logic [DATA_W-1:0] rsp_rdata
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_done  <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_done <= beat_ack;
            if (beat_ack && !lat_write) rsp_rdata <= bus_din;
        end
    end
endmodule

// File: rtl/ext_bus_seq.sv
module ext_bus_seq
    import ebs_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int DATA_W    = 32,
    parameter int NUM_CS    = 4,
    parameter int BURST_LEN = 4,
    localparam int BANK_W   = (NUM_CS > 1) ? $clog2(NUM_CS) : 1,
    localparam int BEAT_W   = (BURST_LEN > 1) ? $clog2(BURST_LEN) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [BANK_W-1:0] req_bank,
    input  logic              req_write,
    input  logic              req_burst,
    input  logic              req_cal,
    input  logic              cal_rd_wr,
    output logic [ADDR_W-1:0] bus_addr,
    output logic              bus_ts_n,
    output logic [NUM_CS-1:0] bus_cs_n,
    output logic              bus_oe_n,
    output logic              bus_rd_wr,
    output logic              bus_burst_n,
    input  logic              bus_ta_n,
    input  logic [DATA_W-1:0] bus_din,
    output logic              rsp_done,
    output logic [DATA_W-1:0] rsp_rdata
);
    seq_state_t        state;
    logic [BEAT_W-1:0] beat;
    logic [BANK_W-1:0] lat_bank;
    logic              lat_write, lat_burst, lat_cal, beat_ack;

    ebs_fsm #(
        .ADDR_W(ADDR_W), .BANK_W(BANK_W), .BURST_LEN(BURST_LEN), .BEAT_W(BEAT_W)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_bank(req_bank), .req_write(req_write), .req_burst(req_burst),
        .req_cal(req_cal), .bus_ta_n(bus_ta_n), .state(state), .beat(beat),
        .lat_addr(bus_addr), .lat_bank(lat_bank), .lat_write(lat_write),
        .lat_burst(lat_burst), .lat_cal(lat_cal), .beat_ack(beat_ack)
    );

    ebs_strobes #(
        .NUM_CS(NUM_CS), .BANK_W(BANK_W), .BURST_LEN(BURST_LEN), .BEAT_W(BEAT_W)
    ) u_strobes (
        .state(state), .beat(beat), .lat_bank(lat_bank), .lat_write(lat_write),
        .lat_burst(lat_burst), .lat_cal(lat_cal), .cal_rd_wr(cal_rd_wr),
        .req_ready(req_ready), .bus_ts_n(bus_ts_n), .bus_cs_n(bus_cs_n),
        .bus_oe_n(bus_oe_n), .bus_rd_wr(bus_rd_wr), .bus_burst_n(bus_burst_n)
    );

    ebs_capture #(
        .DATA_W(DATA_W)
    ) u_capture (
        .clk(clk), .rst_n(rst_n), .beat_ack(beat_ack), .lat_write(lat_write),
        .bus_din(bus_din), .rsp_done(rsp_done), .rsp_rdata(rsp_rdata)
    );
endmodule

// File: rtl/ebs_chk.sv
module ebs_chk #(
    parameter int ADDR_W = 32,
    parameter int NUM_CS = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_ts_n,
    input logic [NUM_CS-1:0] bus_cs_n,
    input logic              bus_oe_n,
    input logic              bus_rd_wr,
    input logic              bus_ta_n,
    input logic              rsp_done,
    input logic              lat_cal
);
    // R1
    ts_single_clk_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_ts_n |=> bus_ts_n);
    // R1
    accept_starts_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (!bus_ts_n && !req_ready));
    // R2
    cs_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~bus_cs_n));
    // R2
    cs_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_ready && !$past(req_ready)) |-> $stable(bus_cs_n));
    // R11
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_ready && !$past(req_ready)) |-> $stable(bus_addr));
    // R4
    oe_not_with_ts_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_ts_n |-> bus_oe_n);
    // R4
    oe_read_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_oe_n |-> (bus_rd_wr && (bus_cs_n != {NUM_CS{1'b1}})));
    // R8
    cal_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lat_cal && !req_ready) |-> (bus_oe_n && (bus_cs_n == {NUM_CS{1'b1}})));
    // R9
    done_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |-> !$past(bus_ta_n));
    // R10
    no_done_after_ts_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_ts_n |=> !rsp_done);
endmodule

bind ext_bus_seq ebs_chk #(.ADDR_W(ADDR_W), .NUM_CS(NUM_CS)) u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .bus_addr(bus_addr), .bus_ts_n(bus_ts_n), .bus_cs_n(bus_cs_n),
    .bus_oe_n(bus_oe_n), .bus_rd_wr(bus_rd_wr), .bus_ta_n(bus_ta_n),
    .rsp_done(rsp_done), .lat_cal(lat_cal)
);

// File: tb/ext_bus_seq_tb.sv
module ext_bus_seq_tb;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 32;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [AW-1:0] req_addr = '0;
    logic [1:0]    req_bank = '0;
    logic          req_write = 1'b0, req_burst = 1'b0, req_cal = 1'b0;
    logic          cal_rd_wr = 1'b0;
    logic [AW-1:0] bus_addr;
    logic          bus_ts_n, bus_oe_n, bus_rd_wr, bus_burst_n;
    logic [3:0]    bus_cs_n;
    logic          bus_ta_n = 1'b1;
    logic [DW-1:0] bus_din = '0;
    logic          rsp_done;
    logic [DW-1:0] rsp_rdata;

    int checks = 0;
    int errors = 0;
    bit running = 1'b0;
    bit finished = 1'b0;

    // reference model state: phase 0 idle, 1 start clock, 2 data
    int            m_phase = 0;
    int            m_beat = 0;
    logic [AW-1:0] m_addr = '0;
    int            m_bank = 0;
    bit            m_write = 0, m_burst = 0, m_cal = 0;
    bit            m_done = 0;
    logic [DW-1:0] m_rdata = '0;
    bit            m_accept = 0;
    logic [15:0]   lfsr = 16'hACE1;

    always #(CLK_PERIOD/2) clk = ~clk;

    ext_bus_seq u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_bank(req_bank), .req_write(req_write),
        .req_burst(req_burst), .req_cal(req_cal), .cal_rd_wr(cal_rd_wr),
        .bus_addr(bus_addr), .bus_ts_n(bus_ts_n), .bus_cs_n(bus_cs_n),
        .bus_oe_n(bus_oe_n), .bus_rd_wr(bus_rd_wr), .bus_burst_n(bus_burst_n),
        .bus_ta_n(bus_ta_n), .bus_din(bus_din), .rsp_done(rsp_done),
        .rsp_rdata(rsp_rdata)
    );

    task automatic check(input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
        end
    endtask

    // behavioural model update on each rising edge
    always @(posedge clk) begin
        m_done   = 0;
        m_accept = 0;
        if (!rst_n) begin
            m_phase = 0;
            m_beat  = 0;
        end else begin
            if (m_phase == 0) begin
                if (req_valid) begin
                    m_accept = 1;
                    m_addr = req_addr; m_bank = int'(req_bank);
                    m_write = req_write; m_burst = req_burst; m_cal = req_cal;
                    m_beat = 0; m_phase = 1;
                end
            end else if (m_phase == 1) begin
                m_phase = 2;  // acknowledge in this clock is ignored (R10)
            end else begin
                if (!bus_ta_n) begin
                    m_done = 1;
                    if (!m_write) m_rdata = bus_din;
                    if (m_write || !m_burst || m_beat == 3) m_phase = 0;
                    else m_beat++;
                end
            end
        end
    end

    // compare on every falling edge, then drive bus-side stimulus
    always @(negedge clk) begin
        if (running) begin
            logic [3:0] e_cs;
            bit e_rw, e_oe, e_burst;
            e_cs = 4'hF;
            if (m_phase != 0 && !m_cal) e_cs[m_bank] = 1'b0;
            e_oe = !(m_phase == 2 && !m_write && !m_cal);
            if (m_phase == 0) e_rw = 1;
            else if (m_cal)   e_rw = cal_rd_wr;
            else              e_rw = !m_write;
            e_burst = !(m_burst && (m_phase == 1 ||
                       (m_phase == 2 && !(!m_write && m_beat == 3))));
            check("R1", "req_ready", 64'(req_ready), 64'(m_phase == 0));
            check("R1", "bus_ts_n", 64'(bus_ts_n), 64'(m_phase != 1));
            check(m_cal ? "R8" : "R2", "bus_cs_n", 64'(bus_cs_n), 64'(e_cs));
            check(m_cal ? "R8" : "R3", "bus_rd_wr", 64'(bus_rd_wr), 64'(e_rw));
            check(m_cal ? "R8" : "R4", "bus_oe_n", 64'(bus_oe_n), 64'(e_oe));
            check("R7", "bus_burst_n", 64'(bus_burst_n), 64'(e_burst));
            check(m_burst ? "R5" : "R9", "rsp_done", 64'(rsp_done), 64'(m_done));
            if (m_done && !m_write)
                check("R9", "rsp_rdata", 64'(rsp_rdata), 64'(m_rdata));
            if (m_phase != 0)
                check("R11", "bus_addr", 64'(bus_addr), 64'(m_addr));
        end
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        bus_ta_n  = lfsr[0] & lfsr[5];   // R6 R10: random acks, also in idle/start
        cal_rd_wr = lfsr[7];
        bus_din   = {lfsr, lfsr ^ 16'h5A3C};
    end

    task automatic issue(input logic [AW-1:0] a, input int bank,
                         input bit wr, input bit bu, input bit ca);
        req_addr = a; req_bank = 2'(bank);
        req_write = wr; req_burst = bu; req_cal = ca;
        req_valid = 1'b1;
        do @(negedge clk); while (!m_accept);
        req_valid = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R12: outputs while reset held
        check("R12", "req_ready", 64'(req_ready), 64'd1);
        check("R12", "bus_ts_n", 64'(bus_ts_n), 64'd1);
        check("R12", "bus_cs_n", 64'(bus_cs_n), 64'hF);
        check("R12", "bus_oe_n", 64'(bus_oe_n), 64'd1);
        check("R12", "rsp_done", 64'(rsp_done), 64'd0);
        rst_n = 1'b1;
        running = 1'b1;
        @(negedge clk);
        // directed cases: R5 single/burst reads, R6 writes, R8 calibration
        issue(32'h0000_1000, 0, 0, 0, 0);
        issue(32'h0000_2000, 1, 1, 0, 0);
        issue(32'h0000_3000, 2, 0, 1, 0);
        issue(32'h0000_4000, 3, 1, 1, 0);
        issue(32'h0000_5000, 1, 0, 0, 1);
        issue(32'h0000_6000, 2, 0, 1, 1);
        issue(32'h0000_7000, 0, 1, 1, 1);
        // back-to-back requests held valid while busy (R1)
        for (int i = 0; i < 300; i++) begin
            logic [15:0] r;
            r = lfsr ^ 16'(i * 40503);
            issue({r, 16'(i)}, int'(r[1:0]), r[2], r[3], (r[6:4] == 3'd0));
            if (r[9]) repeat (int'(r[11:10])) @(negedge clk);
        end
        repeat (20) @(negedge clk);
        running = 1'b0;
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule